// File: doc/BRIEF.md
# Dual Cascaded Interval Timer

The block holds two independent periodic timers. Each has a prescale stage and a divide stage, both 16 bits wide and both loaded over a small 16-bit register bus. The prescale counter counts down once per clock. Each time it passes through zero, the divide counter takes one step. When both stages are at zero in the same cycle, the timer raises a one-clock tick and both stages reload from their registers. A timer therefore fires once every (prescale + 1) × (divide + 1) clocks. Each tick line goes to an external interrupt controller.

Software starts or retunes a timer by writing either of its two registers. The write throws away the countdown in progress and restarts it at once from the new register pair. A timer whose register pair is zero in both fields stays halted. The live state of both countdowns can be read at a block of read-only addresses, kept apart from the write addresses.

Top module: `dual_interval_timer`

## Requirements
- R1: Reset state. After reset the four period registers hold 0xFFFF and all four live counters read 0. No tick is raised, and no timer runs until its first register write.
- R2: A running timer raises tick_o for exactly one cycle. The interval between successive ticks is (P+1)×(D+1) cycles, where P is the prescale register and D is the divide register.
- R3: A write loads both counters of the addressed timer with the updated register pair on the write's clock edge. The first tick follows that edge by exactly (P+1)×(D+1) cycles.
- R4: Writing either register of a timer cancels its pending countdown and restarts the period from that write. The timer's other register keeps its previous value, which is 0xFFFF if it was never written.
- R5: A write that leaves both registers of a timer at zero halts that timer. Its counters hold 0 and no tick follows.
- R6: The two timers run independently. Writing one timer leaves the other's counting and ticks unchanged.
- R7: Address map (addr_i). Writes go to 0 (timer 0 prescale), 1 (timer 0 divide), 2 (timer 1 prescale) and 3 (timer 1 divide). Reads of 4, 5, 6 and 7 return the live counters in that same order. Reads of 0 to 3 return 0, and writes to 4 to 7 change nothing.
- R8: Counting order. The prescale counter decrements every cycle and reloads when it is at zero. The divide counter decrements only in cycles where the prescale counter is at zero, and it reloads when both are at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for both writes and reads |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Live counter read data (combinational) |
| tick_o | output | 2 | One-cycle period tick, one bit per timer |

## Verification
Some properties are checked on every cycle by the assertions:
- a tick never lasts two cycles;
- a write loads the counters with the values written;
- both counters reload together with every tick;
- the counters never exceed their registers;
- a halted timer's state stays frozen;
- writes to the read-only block leave the registers untouched.

Other behaviour can only be shown by the bench scenarios. These are the exact product-form interval, the first-tick offset after a write, cancellation of a countdown by a rewrite, the reset value 0xFFFF showing through a half-written pair, and the independence of the two timers.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int unsigned NUM_TIMERS = 2;
  localparam int unsigned CNT_W      = 16;
endpackage

// File: rtl/dit_regfile.sv
module dit_regfile #(
  parameter int unsigned T  = dit_pkg::NUM_TIMERS,
  parameter int unsigned CW = dit_pkg::CNT_W,
  parameter int unsigned AW = $clog2(T) + 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [CW-1:0]         wr_data_i,
  output logic [T-1:0]          load_o,
  output logic [T-1:0][CW-1:0]  nxt_pre_o,
  output logic [T-1:0][CW-1:0]  nxt_div_o,
  output logic [T-1:0][CW-1:0]  cur_pre_o,
  output logic [T-1:0][CW-1:0]  cur_div_o
);
  localparam int unsigned IW = $clog2(T);

  logic          wr_hit;
  logic [IW-1:0] sel;

  // upper address bit selects the read-only block
  assign wr_hit = wr_en_i && !addr_i[AW-1];
  assign sel    = addr_i[IW:1];

  for (genvar t = 0; t < T; t++) begin : g_tmr
    logic [CW-1:0] pre_q, div_q;

    assign load_o[t]    = wr_hit && (sel == IW'(t));
    assign nxt_pre_o[t] = (load_o[t] && !addr_i[0]) ? wr_data_i : pre_q;
    assign nxt_div_o[t] = (load_o[t] &&  addr_i[0]) ? wr_data_i : div_q;
    assign cur_pre_o[t] = pre_q;
    assign cur_div_o[t] = div_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pre_q <= '1;
        div_q <= '1;
      end else if (load_o[t]) begin
        pre_q <= nxt_pre_o[t];
        div_q <= nxt_div_o[t];
      end
    end
  end

  // R7: writes into the read-only block leave every register untouched
  a_r7_ro_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[AW-1]) |=> ($stable(cur_pre_o) && $stable(cur_div_o)));
endmodule

// File: rtl/dit_countdown.sv
module dit_countdown #(
  parameter int unsigned CW = dit_pkg::CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] ld_pre_i,
  input  logic [CW-1:0] ld_div_i,
  input  logic [CW-1:0] rl_pre_i,
  input  logic [CW-1:0] rl_div_i,
  output logic [CW-1:0] pre_cnt_o,
  output logic [CW-1:0] div_cnt_o,
  output logic          tick_o
);
  logic [CW-1:0] pre_q, div_q;
  logic          run_q, tick_q;
  logic          pre_zero, div_zero;

  assign pre_zero = (pre_q == '0);
  assign div_zero = (div_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      div_q  <= '0;
      run_q  <= 1'b0;
      tick_q <= 1'b0;
    end else if (load_i) begin
      pre_q  <= ld_pre_i;
      div_q  <= ld_div_i;
      run_q  <= |{ld_pre_i, ld_div_i};
      tick_q <= 1'b0;
    end else if (run_q) begin
      tick_q <= pre_zero && div_zero;
      if (pre_zero) begin
        pre_q <= rl_pre_i;
        div_q <= div_zero ? rl_div_i : div_q - 1'b1;
      end else begin
        pre_q <= pre_q - 1'b1;
      end
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign pre_cnt_o = pre_q;
  assign div_cnt_o = div_q;
  assign tick_o    = tick_q;

  // R2: minimum period is two cycles, so a tick never lasts two cycles
  a_r2_single_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |=> !tick_q);
  // R2: a tick coincides with both stages reloaded from the registers
  a_r2_tick_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> (pre_q == rl_pre_i && div_q == rl_div_i));
  // R3: a write loads the counters with the written pair
  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (pre_q == $past(ld_pre_i) && div_q == $past(ld_div_i)));
  // R5: an idle timer keeps its state frozen and never ticks
  a_r5_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !load_i) |=> ($stable(pre_q) && $stable(div_q) && !tick_q));
  // R8: counters never exceed the programmed reload values
  a_r8_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (pre_q <= rl_pre_i && div_q <= rl_div_i));
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer #(
  parameter  int unsigned T  = dit_pkg::NUM_TIMERS,
  parameter  int unsigned CW = dit_pkg::CNT_W,
  localparam int unsigned AW = $clog2(T) + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] wr_data_i,
  output logic [CW-1:0] rd_data_o,
  output logic [T-1:0]  tick_o
);
  localparam int unsigned IW = $clog2(T);

  logic [T-1:0]         load;
  logic [T-1:0][CW-1:0] nxt_pre, nxt_div, cur_pre, cur_div;
  logic [T-1:0][CW-1:0] pre_cnt, div_cnt;
  logic [IW-1:0]        sel;

  dit_regfile #(.T(T), .CW(CW), .AW(AW)) regs_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .load_o    (load),
    .nxt_pre_o (nxt_pre),
    .nxt_div_o (nxt_div),
    .cur_pre_o (cur_pre),
    .cur_div_o (cur_div)
  );

  for (genvar t = 0; t < T; t++) begin : g_cd
    dit_countdown #(.CW(CW)) cd_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load[t]),
      .ld_pre_i  (nxt_pre[t]),
      .ld_div_i  (nxt_div[t]),
      .rl_pre_i  (cur_pre[t]),
      .rl_div_i  (cur_div[t]),
      .pre_cnt_o (pre_cnt[t]),
      .div_cnt_o (div_cnt[t]),
      .tick_o    (tick_o[t])
    );
  end

  assign sel = addr_i[IW:1];

  always_comb begin
    rd_data_o = '0;
    if (addr_i[AW-1]) rd_data_o = addr_i[0] ? div_cnt[sel] : pre_cnt[sel];
  end
endmodule

// File: tb/dual_interval_timer_tb.sv
module dual_interval_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [1:0]  tick;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int q0[$];
  int q1[$];
  bit mon0 = 1'b0;
  bit mon1 = 1'b0;
  bit done = 1'b0;

  dual_interval_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .tick_o(tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // write lands on the next rising edge; returns that edge's cycle number
  task automatic wr(input logic [2:0] a, input logic [15:0] d, output int edge_c);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    edge_c = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
    #1;
  endtask

  // scoreboard monitors: each tick pops its expected cycle
  always @(negedge clk) begin
    if (tick[0] && mon0) begin
      checks++;
      if (q0.size() == 0) begin
        errors++;
        $display("FAIL R2 timer0 unexpected tick: actual %0d expected none", cyc);
      end else begin
        int e;
        e = q0.pop_front();
        if (e != cyc) begin
          errors++;
          $display("FAIL R2 timer0 tick cycle: actual %0d expected %0d", cyc, e);
        end
      end
    end
    if (tick[1] && mon1) begin
      checks++;
      if (q1.size() == 0) begin
        errors++;
        $display("FAIL R6 timer1 unexpected tick: actual %0d expected none", cyc);
      end else begin
        int e;
        e = q1.pop_front();
        if (e != cyc) begin
          errors++;
          $display("FAIL R6 timer1 tick cycle: actual %0d expected %0d", cyc, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int e1, e2, v, stop;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 tick", int'(tick), 0);
    for (int a = 4; a < 8; a++) begin rd(3'(a), v); chk("R1 live count", v, 0); end
    rd(3'd0, v); chk("R7 read of write block", v, 0);

    // R4/R1: write prescale only, divide keeps reset 0xFFFF
    wr(3'd0, 16'd3, e1);
    rd(3'd4, v); chk("R3 pre loaded", v, 3);
    rd(3'd5, v); chk("R4 div reset value kept", v, 16'hFFFF);
    @(negedge clk);
    rd(3'd4, v); chk("R8 pre decrements", v, 2);

    // R2/R3/R6: timer0 P=2 D=3 (period 12), timer1 P=0 D=4 (period 5)
    wr(3'd1, 16'd3, e1);
    wr(3'd0, 16'd2, e1);
    wr(3'd2, 16'd0, e2);
    wr(3'd3, 16'd4, e2);
    q0.delete(); q1.delete();
    stop = e2 + 60;
    for (int k = e1 + 12; k <= stop; k += 12) q0.push_back(k);
    for (int k = e2 + 5; k <= stop; k += 5) q1.push_back(k);
    mon0 = 1'b1; mon1 = 1'b1;
    wait_cyc(stop);
    mon0 = 1'b0; mon1 = 1'b0;
    chk("R2 timer0 missing ticks", q0.size(), 0);
    chk("R6 timer1 missing ticks", q1.size(), 0);

    // R4 restart: P=1 D=1 (period 4), rewrite after 6 cycles cancels the tick due at +8
    wr(3'd0, 16'd1, e1);
    wr(3'd1, 16'd1, e1);
    q0.delete(); q0.push_back(e1 + 4); mon0 = 1'b1;
    wait_cyc(e1 + 4);
    wr(3'd0, 16'd1, e2);
    chk("R4 rewrite edge", e2, e1 + 6);
    q0.push_back(e2 + 4); q0.push_back(e2 + 8);
    wait_cyc(e2 + 9);
    mon0 = 1'b0;
    chk("R4 restart missing ticks", q0.size(), 0);

    // R5 halt both timers
    wr(3'd2, 16'd0, e2);
    wr(3'd3, 16'd0, e2);
    wr(3'd0, 16'd0, e1);
    wr(3'd1, 16'd0, e1);
    q0.delete(); q1.delete(); mon0 = 1'b1; mon1 = 1'b1;
    repeat (20) @(negedge clk);
    for (int a = 4; a < 8; a++) begin rd(3'(a), v); chk("R5 halted count", v, 0); end

    // R7 writes to read block are ignored
    wr(3'd4, 16'd7, e1);
    wr(3'd5, 16'd7, e1);
    rd(3'd4, v); chk("R7 ro write pre", v, 0);
    rd(3'd5, v); chk("R7 ro write div", v, 0);
    repeat (10) @(negedge clk);
    mon0 = 1'b0; mon1 = 1'b0;
    wr(3'd0, 16'd1, e1);
    rd(3'd5, v); chk("R7 div register unchanged", v, 0);

    // R8 counting sequence P=1 D=2
    wr(3'd1, 16'd2, e1);
    q0.delete(); q0.push_back(e1 + 6); mon0 = 1'b1;
    for (int k = 0; k < 6; k++) begin
      rd(3'd4, v); chk("R8 pre sequence", v, 1 - (k % 2));
      rd(3'd5, v); chk("R8 div sequence", v, 2 - (k / 2));
      @(negedge clk);
    end
    wait_cyc(e1 + 7);
    mon0 = 1'b0;
    chk("R2 sequence tick", q0.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule